// File: doc/BRIEF.md
# External Interrupt Source Selector

This block steers GPIO pin levels onto sixteen external interrupt lines. It receives one level per pin for every GPIO port: nine ports of sixteen pins, 144 inputs in all. Output line N can be driven only by pin N of some port. A 4-bit port code for each line picks that port. While the code names a real port, the line follows the level of that port's pin N, one clock later. Activity on the pins of every other port cannot reach the line.

Software reaches the block through a simple word-wide read/write bus that decodes a 1 KiB window. The four line-select registers each hold four port codes. Line N uses select register N/4, bits (N mod 4)×4 and up. Two legacy registers always read zero and discard writes: a memory-remap control and a peripheral-mode control. A compensation-cell register is plain 32-bit storage. The block implements only the bus side of remapping, PHY mode and compensation-cell control, not what those controls would do.

Top module: `irq_src_select`

## Requirements
- R1: Synchronous reset clears every register, every output line and the read data to zero. Port 0 then drives all lines.
- R2: While all select codes are 0, output line N equals input pin_lvl_i[N] from the previous cycle.
- R3: Line N takes its code from select register N/4 at bits (N mod 4)*4 +: 4. Select register K sits at byte offset 0x08 + 4*K.
- R4: When line N's code C is below 9, line_o[N] equals pin_lvl_i[C*16 + N] sampled at the previous rising clock edge. Pins of other ports have no effect on the line.
- R5: When line N's code is 9 to 15, no port matches and line_o[N] holds its last value whatever the pins do.
- R6: A write to a select register keeps bits 15:0. Bits 31:16 of a select register always read zero.
- R7: Writes to offsets 0x00 (remap) and 0x04 (peripheral mode) are discarded, and both offsets read zero.
- R8: Offset 0x20 (compensation) stores all 32 written bits and reads them back.
- R9: Reads from any other offset in the window return zero, and writes to those offsets change no register.
- R10: bus_rdata shows the addressed register one cycle after bus_rd_en and is zero in any cycle that follows no read. A read in the same cycle as a write returns the value from before the write.
- R11: A select write sampled at clock edge k steers the lines computed at edge k+1. The lines computed at edge k still use the previous code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address in the window; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| pin_lvl_i | input | 144 | Pin levels; index = port*16 + pin |
| line_o | output | 16 | Interrupt line levels |

## Verification
Random pin vectors with all codes at zero show whether only port 0's pins reach the lines. Distinct codes per line show whether each line's field sits at the right position and pulls the right pin. Codes of 9 and above, set while the pins keep toggling, separate a hold from a spurious update. A long random run mixes select writes, random reads and pin changes in the same cycles, which exposes off-by-one-cycle errors in when new codes take effect.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 10;
    localparam int WORD_W         = ADDR_W - 2;
    localparam int CODE_W         = 4;
    localparam int LINE_CNT       = 16;
    localparam int FIELDS_PER_REG = 4;
    localparam int SEL_REGS       = LINE_CNT / FIELDS_PER_REG;
    localparam int SEL_BITS       = FIELDS_PER_REG * CODE_W;
    localparam int SEL_IDX_W      = $clog2(SEL_REGS);

    localparam logic [WORD_W-1:0] W_REMAP    = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_PMODE    = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_SEL_BASE = WORD_W'(2);
    localparam logic [WORD_W-1:0] W_SEL_LAST = WORD_W'(2 + SEL_REGS - 1);
    localparam logic [WORD_W-1:0] W_COMP     = WORD_W'(8);

    typedef enum logic [1:0] {
        RK_UNMAPPED,
        RK_ZERO,
        RK_SEL,
        RK_COMP
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [SEL_IDX_W-1:0]   idx;
    } acc_t;

    function automatic acc_t decode_word(input logic [WORD_W-1:0] w);
        acc_t d;
        d.kind = RK_UNMAPPED;
        d.idx  = '0;
        if (w == W_REMAP || w == W_PMODE) begin
            d.kind = RK_ZERO;
        end else if (w >= W_SEL_BASE && w <= W_SEL_LAST) begin
            d.kind = RK_SEL;
            d.idx  = SEL_IDX_W'(w - W_SEL_BASE);
        end else if (w == W_COMP) begin
            d.kind = RK_COMP;
        end
        return d;
    endfunction
endpackage

// File: rtl/isel_regs.sv
module isel_regs
    import irq_src_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [WORD_W-1:0]            word,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [LINE_CNT*CODE_W-1:0]   sel_flat
);
    logic [SEL_REGS-1:0][SEL_BITS-1:0] sel_q;
    logic [DATA_W-1:0]                 comp_q;
    logic [DATA_W-1:0]                 rd_mux;
    acc_t                              acc;

    assign acc = decode_word(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            comp_q <= '0;
        end else if (wr_en) begin
            case (acc.kind)
                RK_SEL:  sel_q[acc.idx] <= wdata[SEL_BITS-1:0];
                RK_COMP: comp_q         <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (acc.kind)
            RK_SEL:  rd_mux = DATA_W'(sel_q[acc.idx]);
            RK_COMP: rd_mux = comp_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end

    assign sel_flat = sel_q;
endmodule

// File: rtl/isel_line_mux.sv
module isel_line_mux
    import irq_src_pkg::*;
#(
    parameter int NPORT = 9
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT*LINE_CNT-1:0]    pin_lvl,
    input  logic [LINE_CNT*CODE_W-1:0]   sel_flat,
    output logic [LINE_CNT-1:0]          lines
);
    for (genvar n = 0; n < LINE_CNT; n++) begin : g_line
        logic [CODE_W-1:0] code;
        logic              hit;
        logic              lvl;

        assign code = sel_flat[n*CODE_W +: CODE_W];

        always_comb begin
            hit = 1'b0;
            lvl = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                if (code == CODE_W'(p)) begin
                    hit = 1'b1;
                    lvl = pin_lvl[p*LINE_CNT + n];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst)      lines[n] <= 1'b0;
            else if (hit) lines[n] <= lvl;
        end
    end
endmodule

// File: rtl/irq_src_select.sv
module irq_src_select
    import irq_src_pkg::*;
#(
    parameter int NPORT = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr_en,
    input  logic                       bus_rd_en,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NPORT*LINE_CNT-1:0]  pin_lvl_i,
    output logic [LINE_CNT-1:0]        line_o
);
    logic [LINE_CNT*CODE_W-1:0] sel_flat;
    logic [WORD_W-1:0]          word;

    assign word = bus_addr[ADDR_W-1:2];

    isel_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .rd_en    (bus_rd_en),
        .word     (word),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .sel_flat (sel_flat)
    );

    isel_line_mux #(.NPORT(NPORT)) u_mux (
        .clk      (clk),
        .rst      (rst),
        .pin_lvl  (pin_lvl_i),
        .sel_flat (sel_flat),
        .lines    (line_o)
    );
endmodule

// File: rtl/irq_src_select_chk.sv
module irq_src_select_chk
    import irq_src_pkg::*;
#(
    parameter int NPORT = 9
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr_en,
    input logic                       bus_rd_en,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NPORT*LINE_CNT-1:0]  pin_lvl_i,
    input logic [LINE_CNT-1:0]        line_o
);
    logic [WORD_W-1:0] w;
    logic              sel_touched;
    logic              is_sel, is_zero, is_unmapped, is_comp;

    assign w           = bus_addr[ADDR_W-1:2];
    assign is_sel      = (w >= WORD_W'(2)) && (w <= WORD_W'(5));
    assign is_zero     = (w == WORD_W'(0)) || (w == WORD_W'(1));
    assign is_comp     = (w == WORD_W'(8));
    assign is_unmapped = !is_sel && !is_zero && !is_comp;

    always_ff @(posedge clk) begin
        if (rst)                      sel_touched <= 1'b0;
        else if (bus_wr_en && is_sel) sel_touched <= 1'b1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (line_o == '0 && bus_rdata == '0));

    a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> bus_rdata == '0);

    a_r7_fixed_regs_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && is_zero) |=> bus_rdata == '0);

    a_r6_sel_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && is_sel) |=> bus_rdata[31:16] == '0);

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && is_unmapped) |=> bus_rdata == '0);

    a_r2_port0_default: assert property (@(posedge clk) disable iff (rst)
        !sel_touched |=> line_o == $past(pin_lvl_i[LINE_CNT-1:0]));

    a_r8_comp_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && is_comp && !bus_wr_en && $past(!rst) &&
         $past(bus_wr_en && bus_addr[ADDR_W-1:2] == WORD_W'(8)))
        |=> bus_rdata == $past(bus_wdata, 2));
endmodule

bind irq_src_select irq_src_select_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_lvl_i (pin_lvl_i),
    .line_o    (line_o)
);

// File: tb/irq_src_select_tb.sv
module irq_src_select_tb;
    localparam int NP = 9;
    localparam int NL = 16;
    localparam int NI = NP * NL;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr_en = 1'b0;
    logic           bus_rd_en = 1'b0;
    logic [9:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NI-1:0]  pin_lvl_i = '0;
    logic [NL-1:0]  line_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [3:0][15:0] sh_sel  = '0;
    logic [31:0]      sh_comp = '0;
    logic [NL-1:0]    m_line  = '0;
    logic [31:0]      m_rd    = '0;
    logic [NI-1:0]    cur_pins = '0;

    always #2.5 clk = ~clk;

    irq_src_select #(.NPORT(NP)) u_dut (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_lvl_i(pin_lvl_i), .line_o(line_o)
    );

    function automatic logic [NL-1:0] next_lines(input logic [NI-1:0] p);
        logic [NL-1:0] r;
        for (int n = 0; n < NL; n++) begin
            logic [3:0] c;
            c = sh_sel[n/4][(n%4)*4 +: 4];
            if (c < NP) r[n] = p[c*NL + n];
            else        r[n] = m_line[n];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        int wd;
        wd = int'(a[9:2]);
        if (wd >= 2 && wd <= 5) return {16'h0, sh_sel[wd-2]};
        if (wd == 8)            return sh_comp;
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic rd, input logic [9:0] a,
                       input logic [31:0] d, input logic [NI-1:0] p);
        int wd;
        bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wdata = d;
        pin_lvl_i = p; cur_pins = p;
        @(posedge clk);
        m_line = next_lines(p);
        m_rd   = rd ? exp_read(a) : 32'h0;
        wd = int'(a[9:2]);
        if (wr) begin
            if (wd >= 2 && wd <= 5) sh_sel[wd-2] = d[15:0];
            else if (wd == 8)       sh_comp = d;
        end
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, cur_pins);
    endtask

    task automatic rd_chk(input logic [9:0] a, input string req);
        cyc(1'b0, 1'b1, a, 32'h0, cur_pins);
        chk(bus_rdata == m_rd, req, bus_rdata, m_rd);
    endtask

    task automatic pins_chk(input logic [NI-1:0] p, input string req);
        cyc(1'b0, 1'b0, 10'h0, 32'h0, p);
        chk(line_o == m_line, req, 32'(line_o), 32'(m_line));
    endtask

    function automatic logic [NI-1:0] rand_pins();
        logic [NI-1:0] r;
        for (int b = 0; b < NI; b++) r[b] = 1'($urandom_range(0, 1));
        return r;
    endfunction

    initial begin : watchdog
        int cnt;
        cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cnt);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(line_o == '0, "R1 lines", 32'(line_o), 32'h0);
        chk(bus_rdata == '0, "R1 rdata", bus_rdata, 32'h0);
        for (int k = 0; k < 9; k++) rd_chk(10'(k*4), "R1 reg after reset");

        // R10: zero when no read
        cyc(1'b0, 1'b0, 10'h20, 32'h0, cur_pins);
        chk(bus_rdata == 32'h0, "R10 idle rdata", bus_rdata, 32'h0);

        // R2: default port 0
        for (int k = 0; k < 8; k++) begin
            logic [NI-1:0] p;
            p = rand_pins();
            pins_chk(p, "R2 port0 default");
            chk(line_o == p[15:0], "R2 direct", 32'(line_o), 32'(p[15:0]));
        end

        // R7: fixed registers
        wr(10'h000, 32'hFFFF_FFFF);
        wr(10'h004, 32'hDEAD_BEEF);
        rd_chk(10'h000, "R7 remap reads zero");
        rd_chk(10'h004, "R7 pmode reads zero");

        // R8: compensation storage
        wr(10'h020, 32'hA5C3_5A3C);
        rd_chk(10'h020, "R8 comp readback");
        chk(bus_rdata == 32'hA5C3_5A3C, "R8 comp literal", bus_rdata, 32'hA5C3_5A3C);

        // R6: upper half dropped
        wr(10'h008, 32'hFFFF_0000);
        rd_chk(10'h008, "R6 sel upper bits");
        chk(bus_rdata == 32'h0, "R6 literal", bus_rdata, 32'h0);

        // R9: unmapped writes and reads
        wr(10'h018, 32'h1234_5678);
        wr(10'h01C, 32'h8765_4321);
        wr(10'h3FC, 32'hFFFF_FFFF);
        rd_chk(10'h018, "R9 unmapped read 0x18");
        rd_chk(10'h3FC, "R9 unmapped read 0x3FC");
        for (int k = 0; k < 9; k++) rd_chk(10'(k*4), "R9 mapped regs intact");

        // R3 / R4: distinct port per line
        wr(10'h008, 32'h0000_3210);
        wr(10'h00C, 32'h0000_7654);
        wr(10'h010, 32'h0000_1098 & 32'h0000_FF08 | 32'h0000_1000);
        wr(10'h014, 32'h0000_5432);
        for (int k = 0; k < 8; k++) pins_chk(rand_pins(), "R3 field position");
        begin
            logic [NI-1:0] p;
            p = '0;
            p[3*NL + 3] = 1'b1;
            pins_chk(p, "R4 single pin port3 line3");
            chk(line_o == 16'h0008, "R4 literal", 32'(line_o), 32'h8);
            p = '1;
            p[3*NL + 3] = 1'b0;
            pins_chk(p, "R4 other ports ignored");
            chk(line_o[3] == 1'b0, "R4 line3 cleared", 32'(line_o[3]), 32'h0);
        end

        // R5: codes with no port hold the line
        pins_chk('1, "R5 preset high");
        wr(10'h008, 32'h0000_FC9A);
        for (int k = 0; k < 6; k++) begin
            pins_chk(rand_pins(), "R5 hold on no-match");
            chk(line_o[3:0] == 4'hF, "R5 held literal", 32'(line_o[3:0]), 32'hF);
        end

        // R11: change of select takes effect one cycle later
        begin
            logic [NI-1:0] p;
            p = '0;
            p[0*NL + 5] = 1'b1;
            p[6*NL + 5] = 1'b0;
            cur_pins = p;
            wr(10'h00C, 32'h0000_0000);
            pins_chk(p, "R11 settle port0");
            chk(line_o[5] == 1'b1, "R11 before", 32'(line_o[5]), 32'h1);
            cyc(1'b1, 1'b0, 10'h00C, 32'h0000_0060, p);
            chk(line_o[5] == 1'b1, "R11 same-edge uses old code", 32'(line_o[5]), 32'h1);
            pins_chk(p, "R11 next edge uses new code");
            chk(line_o[5] == 1'b0, "R11 after", 32'(line_o[5]), 32'h0);
        end

        // R10: read alongside write returns the old value
        cyc(1'b1, 1'b1, 10'h020, 32'h0BAD_F00D, cur_pins);
        chk(bus_rdata == m_rd, "R10 read-during-write old value", bus_rdata, m_rd);

        // R4 / R11 random mix
        for (int it = 0; it < 400; it++) begin
            logic        dw, dr;
            logic [9:0]  a;
            logic [31:0] d;
            dw = ($urandom_range(0, 3) == 0);
            dr = ($urandom_range(0, 3) == 0);
            a  = dw ? 10'(8 + 4*$urandom_range(0, 3)) : 10'(4*$urandom_range(0, 255));
            d  = $urandom();
            cyc(dw, dr, a, d, rand_pins());
            chk(line_o == m_line, "R4 random lines", 32'(line_o), 32'(m_line));
            chk(bus_rdata == m_rd, "R10 random read", bus_rdata, m_rd);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule